// File: doc/BRIEF.md
# Two-Stage Serial Baud Clock Generator

This block derives the bit-rate timing of a serial port from the machine clock. It divides in two steps. A prescaler shared by every operating mode divides the machine clock by a whole number from 1 to 8. A second stage then divides the prescaler output by a power of two. The power of two comes from a 3-bit source-select code and from the operating mode. In clock-synchronous mode the code gives the transfer ratio directly. In asynchronous mode the same code gives a ratio eight times larger, which covers the 8x oversampling of the receiver. The total period in machine-clock cycles is D = N * M, where N is the prescaler ratio and M is the second-stage ratio.

The block has two outputs. A one-cycle tick marks the end of each baud period. A square-wave transfer clock has the same period. A small control state machine has three states. It watches the configuration inputs and restarts both counters cleanly whenever any of them changes. RELOAD clears the counters for one cycle. RUN counts. PARK covers the source codes that point outside the internal generator. The transitions are as follows:

- Reset enters RELOAD.
- Any state goes to PARK when the source code is 110 or 111.
- Otherwise any state goes to RELOAD when the configuration differs from the value registered on the previous cycle.
- Otherwise RELOAD goes to RUN, RUN stays in RUN, and PARK goes to RELOAD.

Top module: `baud_gen_top`

## Requirements
- R1: While `rst_n` is low, `baud_tick` and `xfer_clk` are 0. After reset the configuration registered inside the block is all zeros.
- R2: The prescaler ratio N is `pre_div`+1 when `pre_en` is 1. N is 1 when `pre_en` is 0, and in that case `pre_div` has no effect on the period.
- R3: When `op_mode` is 2'b10 (clock-synchronous), source codes 0 to 5 give M = 1, 2, 4, 8, 16, 32. That is, M = 2^code.
- R4: Every other `op_mode` value (2'b00, 2'b01, 2'b11) selects the asynchronous table, where M = 8 * 2^code for codes 0 to 5.
- R5: With the configuration held, `baud_tick` is high for exactly one cycle in every D = N*M cycles. When D = 1 it stays high.
- R6: While `src_sel` is 3'b110 or 3'b111, `baud_tick` and `xfer_clk` stay 0 from the first clock edge on which that code is sampled.
- R7: After any change to `pre_en`, `pre_div`, `src_sel` or `op_mode`, the next tick is the one registered on the (D+1)th rising edge after the edge that first samples the new value. No shortened period appears in between.
- R8: `xfer_clk` is high for ceil(D/2) cycles and low for floor(D/2) cycles of each period. It is high in the cycle in which `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_en | input | 1 | Prescaler enable |
| pre_div | input | 3 | Prescaler divide code; ratio is code+1 |
| src_sel | input | 3 | Source/ratio select code; 0 to 5 are internal |
| op_mode | input | 2 | Operating mode; 2'b10 is clock-synchronous |
| baud_tick | output | 1 | One-cycle pulse at the end of each baud period |
| xfer_clk | output | 1 | Square-wave transfer clock |

## Verification
The hardest condition to reach is a configuration change that lands in the middle of a long period. The counters must then be flushed and restarted, not carried over into a truncated first period. The vector walk reaches this condition naturally. Each new setting is applied on a falling edge while the previous setting is still counting, at some arbitrary phase. A directed case switches from a 256-cycle period to a 6-cycle one 100 cycles into the period. In every case the bench counts the edges to the first tick of the new setting. It then measures one full period and the high time of the transfer clock within it.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
    typedef enum logic [1:0] {
        ST_RELOAD = 2'd0,
        ST_RUN    = 2'd1,
        ST_PARK   = 2'd2
    } gen_state_e;
endpackage

// File: rtl/baud_cfg_fsm.sv
`timescale 1ns/1ps
module baud_cfg_fsm
    import baud_pkg::*;
#(
    parameter int CFG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             sel_ok,
    output logic             run
);
    gen_state_e       state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             changed;

    assign changed = (cfg_in != cfg_q);

    // state register and configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELOAD;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!sel_ok) begin
            state_d = ST_PARK;
        end else if (changed) begin
            state_d = ST_RELOAD;
        end else begin
            unique case (state_q)
                ST_RELOAD: state_d = ST_RUN;
                ST_RUN:    state_d = ST_RUN;
                ST_PARK:   state_d = ST_RELOAD;
                default:   state_d = ST_RELOAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_RUN:    run = sel_ok && !changed;
            ST_RELOAD: run = 1'b0;
            ST_PARK:   run = 1'b0;
            default:   run = 1'b0;
        endcase
    end
endmodule

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             enable,
    input  logic [PRE_W-1:0] div,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W:0]   ratio,
    output logic             wrap
);
    logic [PRE_W-1:0] limit;

    assign limit = enable ? div : '0;
    assign ratio = {1'b0, limit} + (PRE_W+1)'(1);
    assign wrap  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/baud_stage2.sv
`timescale 1ns/1ps
module baud_stage2 #(
    parameter int SEL_W       = 3,
    parameter int MAX_SEL     = 5,
    parameter int SYNC_SHIFT  = 0,
    parameter int ASYNC_SHIFT = 3,
    parameter int SCNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              adv,
    input  logic              sync_sel,
    input  logic [SEL_W-1:0]  sel,
    output logic [SCNT_W-1:0] cnt,
    output logic [SCNT_W:0]   ratio,
    output logic              last
);
    logic [SCNT_W-1:0] sync_lim  [MAX_SEL+1];
    logic [SCNT_W-1:0] async_lim [MAX_SEL+1];
    logic [SCNT_W-1:0] limit;

    for (genvar c = 0; c <= MAX_SEL; c++) begin : g_tab
        assign sync_lim[c]  = SCNT_W'((1 << (c + SYNC_SHIFT)) - 1);
        assign async_lim[c] = SCNT_W'((1 << (c + ASYNC_SHIFT)) - 1);
    end

    always_comb begin
        limit = '0;
        for (int c = 0; c <= MAX_SEL; c++) begin
            if (sel == SEL_W'(c)) limit = sync_sel ? sync_lim[c] : async_lim[c];
        end
    end

    assign ratio = {1'b0, limit} + (SCNT_W+1)'(1);
    assign last  = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + SCNT_W'(1);
        end
    end
endmodule

// File: rtl/baud_out.sv
`timescale 1ns/1ps
module baud_out #(
    parameter int TOT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_cond,
    input  logic [TOT_W-1:0] total,
    input  logic [TOT_W-1:0] divisor,
    output logic             tick_q,
    output logic             xclk_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            xclk_q <= 1'b0;
        end else begin
            tick_q <= tick_cond;
            xclk_q <= run && (total >= (divisor >> 1));
        end
    end
endmodule

// File: rtl/baud_gen_top.sv
`timescale 1ns/1ps
module baud_gen_top #(
    parameter int         PRE_W       = 3,
    parameter int         SEL_W       = 3,
    parameter int         MODE_W      = 2,
    parameter logic [1:0] SYNC_CODE   = 2'b10,
    parameter int         SYNC_SHIFT  = 0,
    parameter int         ASYNC_SHIFT = 3,
    parameter int         MAX_SEL     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [MODE_W-1:0] op_mode,
    output logic              baud_tick,
    output logic              xfer_clk
);
    localparam int BIG_SHIFT = (ASYNC_SHIFT > SYNC_SHIFT) ? ASYNC_SHIFT : SYNC_SHIFT;
    localparam int SCNT_W    = (MAX_SEL + BIG_SHIFT > 0) ? MAX_SEL + BIG_SHIFT : 1;
    localparam int CFG_W     = 1 + PRE_W + SEL_W + MODE_W;
    localparam int TOT_W     = PRE_W + SCNT_W + 2;

    logic              run, sel_ok, sync_sel;
    logic [PRE_W-1:0]  p_cnt;
    logic [PRE_W:0]    n_ratio;
    logic              p_wrap;
    logic [SCNT_W-1:0] s_cnt;
    logic [SCNT_W:0]   m_ratio;
    logic              s_last;
    logic [TOT_W-1:0]  total, divisor;

    assign sel_ok   = (int'(src_sel) <= MAX_SEL);
    assign sync_sel = (op_mode == MODE_W'(SYNC_CODE));

    baud_cfg_fsm #(.CFG_W(CFG_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in ({pre_en, pre_div, src_sel, op_mode}),
        .sel_ok (sel_ok),
        .run    (run)
    );

    baud_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .enable (pre_en),
        .div    (pre_div),
        .cnt    (p_cnt),
        .ratio  (n_ratio),
        .wrap   (p_wrap)
    );

    baud_stage2 #(
        .SEL_W       (SEL_W),
        .MAX_SEL     (MAX_SEL),
        .SYNC_SHIFT  (SYNC_SHIFT),
        .ASYNC_SHIFT (ASYNC_SHIFT),
        .SCNT_W      (SCNT_W)
    ) u_s2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .adv      (p_wrap),
        .sync_sel (sync_sel),
        .sel      (src_sel),
        .cnt      (s_cnt),
        .ratio    (m_ratio),
        .last     (s_last)
    );

    assign total   = TOT_W'(s_cnt) * TOT_W'(n_ratio) + TOT_W'(p_cnt);
    assign divisor = TOT_W'(n_ratio) * TOT_W'(m_ratio);

    baud_out #(.TOT_W(TOT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick_cond (p_wrap && s_last),
        .total     (total),
        .divisor   (divisor),
        .tick_q    (baud_tick),
        .xclk_q    (xfer_clk)
    );
endmodule

// File: rtl/baud_gen_chk.sv
`timescale 1ns/1ps
module baud_gen_chk #(
    parameter int         PRE_W       = 3,
    parameter int         SEL_W       = 3,
    parameter int         MODE_W      = 2,
    parameter logic [1:0] SYNC_CODE   = 2'b10,
    parameter int         SYNC_SHIFT  = 0,
    parameter int         ASYNC_SHIFT = 3,
    parameter int         MAX_SEL     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pre_en,
    input logic [PRE_W-1:0]  pre_div,
    input logic [SEL_W-1:0]  src_sel,
    input logic [MODE_W-1:0] op_mode,
    input logic              baud_tick,
    input logic              xfer_clk
);
    localparam int CFG_W = 1 + PRE_W + SEL_W + MODE_W;

    logic [CFG_W-1:0] cfg, last_cfg;
    logic [15:0]      gap;
    logic             seen;
    logic [31:0]      exp_d;
    int               shift_amt;

    assign cfg = {pre_en, pre_div, src_sel, op_mode};

    always_comb begin
        shift_amt = ((op_mode == MODE_W'(SYNC_CODE)) ? SYNC_SHIFT : ASYNC_SHIFT) + int'(src_sel);
        exp_d     = (pre_en ? 32'(pre_div) + 32'd1 : 32'd1) << shift_amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cfg <= '0;
            gap      <= '0;
            seen     <= 1'b0;
        end else begin
            last_cfg <= cfg;
            if (baud_tick) gap <= 16'd1;
            else if (gap != 16'hffff) gap <= gap + 16'd1;
            if (cfg != last_cfg) seen <= 1'b0;
            else if (baud_tick) seen <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (!baud_tick && !xfer_clk); // R1
    end

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_sel) > MAX_SEL) |=> (!baud_tick && !xfer_clk)); // R6

    AST_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |=> !baud_tick); // R7

    AST_TICK_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> xfer_clk); // R8

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && seen && (cfg == last_cfg)) |-> (32'(gap) == exp_d)); // R5
endmodule

bind baud_gen_top baud_gen_chk #(
    .PRE_W       (PRE_W),
    .SEL_W       (SEL_W),
    .MODE_W      (MODE_W),
    .SYNC_CODE   (SYNC_CODE),
    .SYNC_SHIFT  (SYNC_SHIFT),
    .ASYNC_SHIFT (ASYNC_SHIFT),
    .MAX_SEL     (MAX_SEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_en    (pre_en),
    .pre_div   (pre_div),
    .src_sel   (src_sel),
    .op_mode   (op_mode),
    .baud_tick (baud_tick),
    .xfer_clk  (xfer_clk)
);

// File: tb/tb_baud_gen_top.sv
`timescale 1ns/1ps
module tb_baud_gen_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_en = 1'b0;
    logic [2:0] pre_div = 3'd0;
    logic [2:0] src_sel = 3'b111;
    logic [1:0] op_mode = 2'b00;
    logic       baud_tick, xfer_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    baud_gen_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_en    (pre_en),
        .pre_div   (pre_div),
        .src_sel   (src_sel),
        .op_mode   (op_mode),
        .baud_tick (baud_tick),
        .xfer_clk  (xfer_clk)
    );

    // {pre_en, pre_div, src_sel, op_mode, expected period}
    localparam int NV = 13;
    localparam logic [20:0] VECS [NV] = '{
        {1'b1, 3'd3, 3'd0, 2'b10, 12'd4},    // R3 sync, N=4, M=1
        {1'b1, 3'd0, 3'd0, 2'b10, 12'd1},    // R3 D=1
        {1'b1, 3'd7, 3'd5, 2'b10, 12'd256},  // R3 N=8, M=32
        {1'b0, 3'd5, 3'd3, 2'b10, 12'd8},    // R2 divide code ignored
        {1'b1, 3'd2, 3'd1, 2'b10, 12'd6},    // R2 N=3
        {1'b1, 3'd0, 3'd0, 2'b00, 12'd8},    // R4 mode 00
        {1'b1, 3'd4, 3'd2, 2'b01, 12'd160},  // R4 mode 01
        {1'b0, 3'd7, 3'd5, 2'b11, 12'd256},  // R4 mode 11, R2 disabled
        {1'b1, 3'd7, 3'd5, 2'b00, 12'd2048}, // R4 largest divisor
        {1'b1, 3'd1, 3'd3, 2'b11, 12'd128},  // R4
        {1'b1, 3'd6, 3'd4, 2'b10, 12'd112},  // R3
        {1'b1, 3'd2, 3'd0, 2'b10, 12'd3},    // R8 odd period
        {1'b1, 3'd6, 3'd0, 2'b10, 12'd7}     // R8 odd period
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic apply(input logic [20:0] v);
        @(negedge clk);
        pre_en  = v[20];
        pre_div = v[19:17];
        src_sel = v[16:14];
        op_mode = v[13:12];
    endtask

    task automatic measure(input int d);
        int n = 0;
        int hi = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!baud_tick && n < 5000);
        check(n == d + 2, "R7 first-tick latency", n, d + 2);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
            if (xfer_clk) hi++;
        end while (!baud_tick && n < 5000);
        check(n == d, "R5 tick period", n, d);
        check(hi == (d + 1) / 2, "R8 xfer_clk high time", hi, (d + 1) / 2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int quiet;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!baud_tick, "R1 tick in reset", baud_tick, 0);
        check(!xfer_clk, "R1 xfer_clk in reset", xfer_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: parked source code after reset
        quiet = 0;
        for (int k = 0; k < 50; k++) begin
            @(posedge clk); #1;
            if (baud_tick || xfer_clk) quiet++;
        end
        check(quiet == 0, "R6 parked after reset", quiet, 0);

        // vector walk: each new setting lands mid-period of the previous one
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            measure(int'(VECS[i][11:0]));
        end

        // R6: park in the middle of a running period
        apply({1'b1, 3'd3, 3'd0, 2'b10, 12'd4});
        repeat (5) @(posedge clk);
        @(negedge clk);
        src_sel = 3'b110;
        quiet = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            if (baud_tick || xfer_clk) quiet++;
        end
        check(quiet == 0, "R6 parked mid-run", quiet, 0);

        // R7: change part way through a long period
        apply({1'b1, 3'd7, 3'd5, 2'b10, 12'd256});
        repeat (100) @(posedge clk);
        apply({1'b1, 3'd2, 3'd1, 2'b10, 12'd6});
        measure(6);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule